// File: doc/BRIEF.md
# Indexed Block-Access Register Slave for a Two-Wire Serial Bus

This block is a two-wire (SMBus/I2C-style) slave. It gives a host indexed block access to a small bank of 8-bit control registers, such as the registers that configure a clock generator. The block samples the bus clock and data lines with its own system clock and finds start, repeated-start and stop conditions on the sampled lines. It decodes a fixed 7-bit device address and acknowledges only its own write and read address bytes. It pulls the data line low through an open-drain enable when it acknowledges or sends a zero bit.

Every transfer carries a byte count. On a write the host sends the address, a starting index, a count byte and then the data bytes. On a read the host first sets the index with a write-framed header. It then issues a repeated start and the read address. The slave answers with the stored count byte and then with register contents, starting at that index. The index advances after every data byte and wraps around the bank. The bank and the count register are always visible as parallel outputs.

Top module: `smb_regbank_slave`

## Requirements
- R1: The slave acknowledges only the address bytes 0xDC (7-bit address 0x6E, bit 0 = 0 meaning write) and 0xDD (same address, bit 0 = 1 meaning read). For any other address byte it leaves SDA released in the acknowledge slot. It then acknowledges nothing and changes nothing until the next start condition.
- R2: In a write transfer the slave acknowledges the address, the index byte, the count byte and every data byte. Data byte k of the transfer is stored in register (N + k) mod 8, where N is the index byte and only its low 3 bits are used.
- R3: The count byte of a write transfer is stored in a dedicated count register. A later read returns this register as its first byte.
- R4: After a repeated start and the address 0xDD, the slave transmits the count register, most significant bit first. It then transmits register N, N+1 and so on, wrapping from register 7 to register 0, for as long as the host acknowledges.
- R5: A not-acknowledge from the host after a transmitted byte makes the slave release SDA and become idle. Further SCL pulses draw no drive from it until the next start condition.
- R6: A stop or start condition in the middle of a byte discards that partial byte. Registers written by complete earlier bytes keep their new values.
- R7: After reset every data register reads 0x00, the count register reads 0x08 and SDA is released.
- R8: The SDA drive enable and the register outputs change only while SCL is low. A data byte is stored at the SCL falling edge that opens its acknowledge slot.
- R9: The bus lines pass through a two-flop synchronizer. The SDA drive therefore never turns on until SCL has been low for at least three system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | High pulls the data line low (open drain) |
| regs_o | output | 64 | Register bank, register i in bits [8i+7:8i] |
| cnt_o | output | 8 | Count register returned first on a read |

## Verification
A wrong index or role state inside the slave shows at the ports within one byte time. A write lands in the wrong lane of `regs_o` at the falling edge that opens the acknowledge slot, and a read returns the wrong byte during the next eight SCL pulses. A stuck drive state shows up as a missing or extra acknowledge in the ninth bit slot, or as SDA held low after a not-acknowledge. The register outputs are compared with a behavioural model on every clock, so a stray write, such as one caused by a partial byte or a rejected address, is caught in the system clock cycle in which it happens.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } smb_st_e;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_INDEX,
    RL_COUNT,
    RL_DATA
  } smb_role_e;
endpackage

// File: rtl/smb_rst_sync.sv
module smb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_prev_q, sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q      <= '1;
      sda_q      <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_q      <= {scl_q[STAGES-2:0], scl_i};
      sda_q      <= {sda_q[STAGES-2:0], sda_i};
      scl_prev_q <= scl_q[STAGES-1];
      sda_prev_q <= sda_q[STAGES-1];
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign scl_rise = scl_s & ~scl_prev_q;
  assign scl_fall = ~scl_s & scl_prev_q;
  // data edges qualified by a clock line that is high before and after
  assign start_p  = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_p   = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int         NREG    = 8,
  parameter logic [7:0] CNT_RST = 8'h08,
  localparam int        IW      = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [7:0]      wr_data,
  input  logic            cnt_we,
  input  logic [7:0]      cnt_data,
  input  logic [IW-1:0]   rd_idx,
  output logic [7:0]      rd_data,
  output logic [NREG*8-1:0] regs_o,
  output logic [7:0]      cnt_o
);
  logic [7:0] bank_q [NREG];
  logic [7:0] cnt_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bank_q[g] <= '0;
      else if (hit) bank_q[g] <= wr_data;
    end
    assign regs_o[g*8 +: 8] = bank_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_RST;
    else if (cnt_we) cnt_q <= cnt_data;
  end

  assign cnt_o   = cnt_q;
  assign rd_data = bank_q[rd_idx];
endmodule

// File: rtl/smb_fsm.sv
module smb_fsm
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6E,
  parameter int         NREG     = 8,
  localparam int        IW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic [7:0]    rd_data,
  input  logic [7:0]    cnt_i,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          cnt_we,
  output logic [7:0]    cnt_data,
  output logic [IW-1:0] rd_idx,
  output logic          sda_oe
);
  smb_st_e   st_q, st_d;
  smb_role_e role_q, role_d;
  logic [3:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          rw_q, rw_d;
  logic          oe_q, oe_d;
  logic          hack_q, hack_d;

  always_comb begin
    st_d    = st_q;
    role_d  = role_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    rw_d    = rw_q;
    oe_d    = oe_q;
    hack_d  = hack_q;
    wr_en   = 1'b0;
    cnt_we  = 1'b0;
    if (start_p) begin
      st_d   = ST_RX;
      role_d = RL_ADDR;
      bit_d  = '0;
      oe_d   = 1'b0;
    end else if (stop_p) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_RX: begin
          if (scl_rise && bit_q < 4'd8) begin
            sh_d  = {sh_q[6:0], sda_s};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            st_d = ST_ACK;
            oe_d = 1'b1;
            unique case (role_q)
              RL_ADDR: begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  rw_d = sh_q[0];
                end else begin
                  st_d = ST_IDLE;
                  oe_d = 1'b0;
                end
              end
              RL_INDEX: idx_d  = sh_q[IW-1:0];
              RL_COUNT: cnt_we = 1'b1;
              RL_DATA: begin
                wr_en = 1'b1;
                idx_d = idx_q + IW'(1);
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_d = '0;
            if (role_q == RL_ADDR && rw_q) begin
              st_d   = ST_TX;
              role_d = RL_DATA;
              sh_d   = cnt_i;
              oe_d   = ~cnt_i[7];
            end else begin
              st_d = ST_RX;
              oe_d = 1'b0;
              unique case (role_q)
                RL_ADDR:  role_d = RL_INDEX;
                RL_INDEX: role_d = RL_COUNT;
                RL_COUNT: role_d = RL_DATA;
                RL_DATA:  role_d = RL_DATA;
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              st_d = ST_RACK;
              oe_d = 1'b0;
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              bit_d = bit_q + 4'd1;
              oe_d  = ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            hack_d = ~sda_s;
          end else if (scl_fall) begin
            if (hack_q) begin
              st_d  = ST_TX;
              sh_d  = rd_data;
              idx_d = idx_q + IW'(1);
              bit_d = '0;
              oe_d  = ~rd_data[7];
            end else begin
              st_d = ST_IDLE;
              oe_d = 1'b0;
            end
          end
        end
        default: begin
          st_d = ST_IDLE;
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      role_q <= RL_ADDR;
      bit_q  <= '0;
      sh_q   <= '0;
      idx_q  <= '0;
      rw_q   <= 1'b0;
      oe_q   <= 1'b0;
      hack_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      role_q <= role_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      rw_q   <= rw_d;
      oe_q   <= oe_d;
      hack_q <= hack_d;
    end
  end

  assign wr_idx   = idx_q;
  assign wr_data  = sh_q;
  assign cnt_data = sh_q;
  assign rd_idx   = idx_q;
  assign sda_oe   = oe_q;
endmodule

// File: rtl/smb_regbank_slave.sv
module smb_regbank_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h6E,
  parameter int         NREG        = 8,
  parameter logic [7:0] CNT_RST     = 8'h08,
  parameter int         SYNC_STAGES = 2,
  localparam int        IW          = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o,
  output logic [7:0]        cnt_o
);
  logic          rst_int_n;
  logic          scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic          wr_en, cnt_we;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [7:0]    wr_data, cnt_data, rd_data;

  smb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  smb_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
    .rd_data(rd_data), .cnt_i(cnt_o), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .cnt_we(cnt_we), .cnt_data(cnt_data),
    .rd_idx(rd_idx), .sda_oe(sda_oe)
  );

  smb_regfile #(.NREG(NREG), .CNT_RST(CNT_RST)) u_rf (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .cnt_we(cnt_we), .cnt_data(cnt_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .regs_o(regs_o), .cnt_o(cnt_o)
  );

  // scl_s is kept for visibility of the sampled clock line
  logic unused_scl;
  assign unused_scl = scl_s;
endmodule

// File: rtl/smb_slave_chk.sv
module smb_slave_chk #(
  parameter int         NREG    = 8,
  parameter logic [7:0] CNT_RST = 8'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [NREG*8-1:0] regs_o,
  input logic [7:0]        cnt_o
);
  // R8: drive enable moves only while the bus clock is low
  a_r8_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  // R8: stored values move only while the bus clock is low
  a_r8_regs_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((regs_o != $past(regs_o)) || (cnt_o != $past(cnt_o))) |-> !scl_i);

  // R9: synchronizer latency before any drive turns on
  a_r9_oe_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> (!scl_i && !$past(scl_i) && !$past(scl_i, 2)));

  // R7: reset leaves the line released and the count at its default
  a_r7_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!sda_oe && cnt_o == CNT_RST && regs_o == '0));
endmodule

bind smb_regbank_slave smb_slave_chk #(.NREG(NREG), .CNT_RST(CNT_RST)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .regs_o(regs_o), .cnt_o(cnt_o)
);

// File: tb/sim_smb_regbank_slave.sv
`timescale 1ns/1ps
module sim_smb_regbank_slave;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic [63:0] regs_o;
  logic [7:0] cnt_o;
  wire sda_bus = sda_h & ~sda_oe;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  logic [7:0] mreg [8];
  logic [7:0] mcnt;
  int midx;

  always #5 clk = ~clk;

  smb_regbank_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
    .sda_oe(sda_oe), .regs_o(regs_o), .cnt_o(cnt_o)
  );

  function automatic logic [63:0] pack_model();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = mreg[i];
    return v;
  endfunction

  // per-clock comparison of the stored state against the model (R2, R3, R6)
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      compared++;
      if (regs_o !== pack_model() || cnt_o !== mcnt) begin
        mismatched++;
        $display("FAIL R2 state regs=%h cnt=%h expected regs=%h cnt=%h",
                 regs_o, cnt_o, pack_model(), mcnt);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog actual=%0d cycles expected=<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_h = 1'b0; tick(H);
    scl_h = 1'b0; tick(H);
  endtask

  task automatic bus_rstart();
    tick(2); sda_h = 1'b1; tick(H - 2);
    scl_h = 1'b1; tick(H);
    sda_h = 1'b0; tick(H);
    scl_h = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    tick(2); sda_h = 1'b0; tick(H - 2);
    scl_h = 1'b1; tick(H);
    sda_h = 1'b1; tick(H);
  endtask

  // kind: 0 address/ignored, 1 index, 2 count, 3 data
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input int kind,
                           input string req);
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      tick(2); sda_h = b[i]; tick(H - 2);
      scl_h = 1'b1; tick(H);
      if (i == 0 && kind >= 2) cmp_en = 1'b0;
      scl_h = 1'b0;
    end
    tick(2); sda_h = 1'b1; tick(H - 2);
    scl_h = 1'b1; tick(H / 2);
    ack = !sda_bus;
    check(req, {7'd0, ack}, {7'd0, exp_ack});
    if (exp_ack) begin
      if (kind == 1) midx = b % 8;
      if (kind == 2) mcnt = b;
      if (kind == 3) begin mreg[midx] = b; midx = (midx + 1) % 8; end
    end
    cmp_en = 1'b1;
    tick(H / 2);
    scl_h = 1'b0;
  endtask

  task automatic send_partial(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      tick(2); sda_h = b[i]; tick(H - 2);
      scl_h = 1'b1; tick(H);
      scl_h = 1'b0;
    end
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit host_ack, input string req);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl_h = 1'b1; tick(H / 2);
      got[i] = sda_bus;
      tick(H / 2); scl_h = 1'b0;
    end
    check(req, got, exp);
    tick(2); sda_h = host_ack ? 1'b0 : 1'b1; tick(H - 2);
    scl_h = 1'b1; tick(H);
    scl_h = 1'b0;
    tick(2); sda_h = 1'b1;
  endtask

  task automatic read_data(input int n);
    for (int k = 0; k < n; k++) begin
      recv_byte(mreg[midx], k != n - 1, "R4 read data");
      midx = (midx + 1) % 8;
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
    mcnt = 8'h08;
    midx = 0;
    tick(4);
    rst_n = 1'b1;
    tick(6);
    // R7 reset state
    check("R7 sda_oe", {7'd0, sda_oe}, 8'h00);
    check("R7 cnt", cnt_o, 8'h08);
    check("R7 reg0", regs_o[7:0], 8'h00);
    cmp_en = 1'b1;

    // R2/R3 plain write at index 3
    bus_start();
    send_byte(8'hDC, 1, 0, "R1 write address ack");
    send_byte(8'h03, 1, 1, "R2 index ack");
    send_byte(8'h04, 1, 2, "R3 count ack");
    send_byte(8'hA1, 1, 3, "R2 data ack");
    send_byte(8'hB2, 1, 3, "R2 data ack");
    send_byte(8'hC3, 1, 3, "R2 data ack");
    send_byte(8'hD4, 1, 3, "R2 data ack");
    bus_stop();
    check("R2 reg4", regs_o[39:32], 8'hB2);

    // R2 wrap: index 0x0E selects register 6, then 7, then 0
    bus_start();
    send_byte(8'hDC, 1, 0, "R1 write address ack");
    send_byte(8'h0E, 1, 1, "R2 index ack");
    send_byte(8'h03, 1, 2, "R3 count ack");
    send_byte(8'h11, 1, 3, "R2 data ack");
    send_byte(8'h22, 1, 3, "R2 data ack");
    send_byte(8'h33, 1, 3, "R2 data ack");
    bus_stop();
    check("R2 wrap reg0", regs_o[7:0], 8'h33);

    // R3/R4/R5 read from index 5 with wrap, then NACK
    bus_start();
    send_byte(8'hDC, 1, 0, "R1 write address ack");
    send_byte(8'h05, 1, 1, "R4 index ack");
    bus_rstart();
    send_byte(8'hDD, 1, 0, "R1 read address ack");
    recv_byte(mcnt, 1, "R3 count first");
    read_data(4);
    tick(2 * H);
    check("R5 released after nack", {7'd0, sda_oe}, 8'h00);
    send_byte(8'hFF, 0, 0, "R5 idle after nack");
    bus_stop();

    // R1 foreign addresses are ignored until the next start
    bus_start();
    send_byte(8'hA0, 0, 0, "R1 foreign address nack");
    send_byte(8'h55, 0, 0, "R1 ignored byte");
    bus_stop();
    bus_start();
    send_byte(8'hDE, 0, 0, "R1 neighbour address nack");
    send_byte(8'h00, 0, 0, "R1 ignored byte");
    bus_stop();

    // R6 early stop mid-byte
    bus_start();
    send_byte(8'hDC, 1, 0, "R1 write address ack");
    send_byte(8'h01, 1, 1, "R6 index ack");
    send_byte(8'h02, 1, 2, "R6 count ack");
    send_byte(8'h5A, 1, 3, "R6 data ack");
    send_partial(8'hFF, 4);
    bus_stop();
    check("R6 partial discarded reg2", regs_o[23:16], 8'h00);
    check("R6 kept reg1", regs_o[15:8], 8'h5A);

    // R6 early repeated start mid-byte, then read continues at index 3
    bus_start();
    send_byte(8'hDC, 1, 0, "R1 write address ack");
    send_byte(8'h02, 1, 1, "R6 index ack");
    send_byte(8'h01, 1, 2, "R6 count ack");
    send_byte(8'h77, 1, 3, "R6 data ack");
    send_partial(8'h00, 3);
    bus_rstart();
    send_byte(8'hDD, 1, 0, "R1 read address ack");
    recv_byte(mcnt, 1, "R3 count first");
    read_data(1);
    bus_stop();
    check("R6 partial discarded reg3", regs_o[31:24], 8'hA1);

    // R4 read starting at the last register wraps to register 0
    bus_start();
    send_byte(8'hDC, 1, 0, "R1 write address ack");
    send_byte(8'h07, 1, 1, "R4 index ack");
    bus_rstart();
    send_byte(8'hDD, 1, 0, "R1 read address ack");
    recv_byte(mcnt, 1, "R3 count first");
    read_data(3);
    bus_stop();
    check("R5 idle at end", {7'd0, sda_oe}, 8'h00);

    tick(20);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule